// File: doc/BRIEF.md
# Backup-Battery Freshness Seal Controller

This block picks the source for a retained-RAM supply rail: the main supply or a backup battery. It works only on digital flags from analog comparators that sit outside it. It also handles a shipping seal, which keeps the battery off the rail and off the internal circuits until the product is powered for the first time. A factory arms the seal by holding a supervisory output pin at ground through one reset-timeout window and then removing main power. The block reads that pin at the half and three-quarter points of the window.

The block also produces two override levels for the power-fail output pin. One forces the pin high during the reset-timeout window. The other pulls it low whenever the supply is below the battery. The state machine has three states:

- `PATH_MAIN`: the main supply feeds the rail.
- `PATH_BATT`: the battery feeds the rail.
- `PATH_SEALED`: the battery is disconnected.

The transitions are:

- `MAIN->BATT`: the supply is low and not above the battery, and the seal is not armed.
- `MAIN->SEALED`: the supply is low and the seal is armed.
- `BATT->MAIN`: the supply is good, or the supply is above the battery.
- `SEALED->MAIN`: the supply is good.

Every other case holds the current state.

Top module: `freshness_seal_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after reset with the supply good, main_en=1, batt_en=0, seal_active=0 and both power-fail overrides are 0.
- R2: batt_en rises only one clock edge after a cycle in which supply_ok=0 and supply_gt_batt=0 with the seal not armed; while supply_ok=0 and supply_gt_batt=1 from PATH_MAIN, main_en stays 1.
- R3: Any clock edge that samples supply_ok=1 leaves main_en=1 and batt_en=0, whatever supply_gt_batt is; from the battery path, supply_gt_batt=1 also returns to main at the next edge.
- R4: pf_hold_hi is 1 exactly while tmo_active=1 and supply_gt_batt=1, and it is never 1 together with pf_pull_lo.
- R5: Number the window cycles from 0, where cycle 0 is the first cycle with tmo_active=1. pin_sense is sampled only in cycles TRP_CYCLES/2 and 3*TRP_CYCLES/4. The seal arms only if it reads 0 at both points, and its level in every other cycle is ignored. An armed seal turns the next supply_ok fall into entry to PATH_SEALED.
- R6: mr_n must read 1 at both sample points for the seal to arm. A low mr_n after arming has no effect.
- R7: In PATH_SEALED, batt_en stays 0 whatever supply_gt_batt is, main_en equals supply_gt_batt, and seal_active=1.
- R8: The seal is released by the first clock edge that samples supply_ok=1. A later supply loss then takes the battery path.
- R9: pf_pull_lo equals the inverse of supply_gt_batt.
- R10: The start of each new window discards earlier samples and any arm that has not been used.
- R11: main_en and batt_en are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply is above the reset threshold |
| supply_gt_batt | input | 1 | Supply is above the battery voltage |
| tmo_active | input | 1 | Reset-timeout window in progress |
| mr_n | input | 1 | Manual reset level, low is active |
| pin_sense | input | 1 | Sensed level of the sealing pin |
| main_en | output | 1 | Main supply switch enable |
| batt_en | output | 1 | Battery switch enable |
| seal_active | output | 1 | Battery held disconnected by the seal |
| pf_hold_hi | output | 1 | Force the power-fail output high |
| pf_pull_lo | output | 1 | Drive the power-fail output low |

## Verification
The bench builds the block with TRP_CYCLES=16, so the sample points fall in window cycles 8 and 12. This lets each window run in a few cycles, which leaves room for many arming attempts. With that setting the bench can place a low pin at exactly one sample point, hold the pin low everywhere except the sample points, and pull manual reset low at either point. It also runs two windows back to back and checks that the second one discards the arm from the first.

// File: rtl/seal_pkg.sv
package seal_pkg;
    typedef enum logic [1:0] {
        PATH_MAIN   = 2'd0,
        PATH_BATT   = 2'd1,
        PATH_SEALED = 2'd2
    } path_state_e;
endpackage

// File: rtl/seal_window_sampler.sv
module seal_window_sampler #(
    parameter int TRP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tmo_active,
    input  logic mr_n,
    input  logic pin_sense,
    output logic armed_o
);
    localparam int CW      = $clog2(TRP_CYCLES + 1);
    localparam int HALF_PT = TRP_CYCLES / 2;
    localparam int Q3_PT   = (3 * TRP_CYCLES) / 4;

    logic [CW-1:0] cnt_q;
    logic          half_low_q;
    logic          armed_q;
    logic          win_start;
    logic          pin_ok;

    assign win_start = tmo_active && (cnt_q == '0);
    assign pin_ok    = !pin_sense && mr_n;

    // Position inside the reset-timeout window, saturating at its end
    always_ff @(posedge clk) begin
        if (!rst_n || !tmo_active) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(TRP_CYCLES)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // First sample point result
    always_ff @(posedge clk) begin
        if (!rst_n || win_start) begin
            half_low_q <= 1'b0;
        end else if (tmo_active && cnt_q == CW'(HALF_PT)) begin
            half_low_q <= pin_ok;
        end
    end

    // Arm flag: held until the supply drops or a new window starts
    always_ff @(posedge clk) begin
        if (!rst_n || win_start || !supply_ok) begin
            armed_q <= 1'b0;
        end else if (tmo_active && cnt_q == CW'(Q3_PT) && half_low_q && pin_ok) begin
            armed_q <= 1'b1;
        end
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/rail_path_fsm.sv
module rail_path_fsm
    import seal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic supply_gt_batt,
    input  logic armed_i,
    output logic main_en,
    output logic batt_en,
    output logic seal_active
);
    path_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PATH_MAIN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PATH_MAIN: begin
                if (!supply_ok && armed_i) begin
                    state_d = PATH_SEALED;
                end else if (!supply_ok && !supply_gt_batt) begin
                    state_d = PATH_BATT;
                end
            end
            PATH_BATT: begin
                if (supply_ok || supply_gt_batt) begin
                    state_d = PATH_MAIN;
                end
            end
            PATH_SEALED: begin
                if (supply_ok) begin
                    state_d = PATH_MAIN;
                end
            end
            default: state_d = PATH_MAIN;
        endcase
    end

    always_comb begin
        main_en     = 1'b0;
        batt_en     = 1'b0;
        seal_active = 1'b0;
        unique case (state_q)
            PATH_MAIN:   main_en = 1'b1;
            PATH_BATT:   batt_en = 1'b1;
            PATH_SEALED: begin
                seal_active = 1'b1;
                main_en     = supply_gt_batt;
            end
            default: main_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/pf_override.sv
module pf_override (
    input  logic supply_gt_batt,
    input  logic tmo_active,
    output logic pf_hold_hi,
    output logic pf_pull_lo
);
    assign pf_pull_lo = !supply_gt_batt;
    assign pf_hold_hi = tmo_active && supply_gt_batt;
endmodule

// File: rtl/freshness_seal_ctrl.sv
module freshness_seal_ctrl #(
    parameter int TRP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic supply_gt_batt,
    input  logic tmo_active,
    input  logic mr_n,
    input  logic pin_sense,
    output logic main_en,
    output logic batt_en,
    output logic seal_active,
    output logic pf_hold_hi,
    output logic pf_pull_lo
);
    logic armed;

    seal_window_sampler #(.TRP_CYCLES(TRP_CYCLES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .tmo_active (tmo_active),
        .mr_n       (mr_n),
        .pin_sense  (pin_sense),
        .armed_o    (armed)
    );

    rail_path_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .supply_gt_batt (supply_gt_batt),
        .armed_i        (armed),
        .main_en        (main_en),
        .batt_en        (batt_en),
        .seal_active    (seal_active)
    );

    pf_override u_pf (
        .supply_gt_batt (supply_gt_batt),
        .tmo_active     (tmo_active),
        .pf_hold_hi     (pf_hold_hi),
        .pf_pull_lo     (pf_pull_lo)
    );
endmodule

// File: rtl/freshness_seal_chk.sv
module freshness_seal_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic supply_gt_batt,
    input logic main_en,
    input logic batt_en,
    input logic seal_active,
    input logic pf_hold_hi,
    input logic pf_pull_lo
);
    AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_en && batt_en)); // R11

    AST_BATT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_en) |-> (!$past(supply_ok) && !$past(supply_gt_batt))); // R2

    AST_GOOD_NO_BATT: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok |=> (main_en && !batt_en)); // R3

    AST_PF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_hold_hi && pf_pull_lo)); // R4

    AST_SEAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seal_active) |-> (!$past(supply_ok) && $past(main_en))); // R5

    AST_SEAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seal_active && !supply_ok) |=> (seal_active && !batt_en)); // R7

    AST_SEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (seal_active && supply_ok) |=> !seal_active); // R8
endmodule

bind freshness_seal_ctrl freshness_seal_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .supply_gt_batt (supply_gt_batt),
    .main_en        (main_en),
    .batt_en        (batt_en),
    .seal_active    (seal_active),
    .pf_hold_hi     (pf_hold_hi),
    .pf_pull_lo     (pf_pull_lo)
);

// File: tb/freshness_seal_ctrl_tb.sv
module freshness_seal_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TRP        = 16;
    localparam int HALF_IDX   = TRP / 2;
    localparam int Q3_IDX     = (3 * TRP) / 4;

    // expected vector: {main_en, batt_en, seal_active, pf_hold_hi, pf_pull_lo}
    localparam logic [4:0] E_MAIN      = 5'b10000;
    localparam logic [4:0] E_MAIN_LO   = 5'b10001;
    localparam logic [4:0] E_BATT      = 5'b01001;
    localparam logic [4:0] E_SEAL_LO   = 5'b00101;
    localparam logic [4:0] E_SEAL_MAIN = 5'b10100;
    localparam logic [4:0] E_WINDOW    = 5'b10010;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1, supply_gt_batt = 1'b1, tmo_active = 1'b0;
    logic mr_n = 1'b1, pin_sense = 1'b1;
    logic main_en, batt_en, seal_active, pf_hold_hi, pf_pull_lo;

    int n_cmp = 0;
    int n_bad = 0;
    exp_item_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    freshness_seal_ctrl #(.TRP_CYCLES(TRP)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .supply_gt_batt (supply_gt_batt),
        .tmo_active     (tmo_active),
        .mr_n           (mr_n),
        .pin_sense      (pin_sense),
        .main_en        (main_en),
        .batt_en        (batt_en),
        .seal_active    (seal_active),
        .pf_hold_hi     (pf_hold_hi),
        .pf_pull_lo     (pf_pull_lo)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pops one expected item per clock edge that has one pending
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                logic [4:0] act;
                it  = sb_q.pop_front();
                act = {main_en, batt_en, seal_active, pf_hold_hi, pf_pull_lo};
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: outputs actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver: set inputs away from the edge and queue the post-edge result
    task automatic step(input logic ok, input logic gb, input logic tmo,
                        input logic mr, input logic pin,
                        input logic [4:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        supply_ok      = ok;
        supply_gt_batt = gb;
        tmo_active     = tmo;
        mr_n           = mr;
        pin_sense      = pin;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic run_window(input logic pin_other, input logic pin_h, input logic pin_q,
                              input logic mr_h, input logic mr_q);
        for (int i = 0; i < TRP; i++) begin
            logic p;
            logic m;
            p = (i == HALF_IDX) ? pin_h : ((i == Q3_IDX) ? pin_q : pin_other);
            m = (i == HALF_IDX) ? mr_h  : ((i == Q3_IDX) ? mr_q  : 1'b1);
            step(1'b1, 1'b1, 1'b1, m, p, E_WINDOW, "R4");
        end
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, E_MAIN, "R4");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        n_cmp++;
        if ({main_en, batt_en, seal_active, pf_hold_hi, pf_pull_lo} !== E_MAIN) begin
            n_bad++;
            $display("FAIL R1: in reset actual=%b expected=%b",
                     {main_en, batt_en, seal_active, pf_hold_hi, pf_pull_lo}, E_MAIN);
        end
        rst_n = 1'b1;
        step(1, 1, 0, 1, 1, E_MAIN, "R1");

        // Path selection
        step(1, 0, 0, 1, 1, E_MAIN_LO, "R3");
        step(1, 0, 0, 1, 1, E_MAIN_LO, "R9");
        step(0, 1, 0, 1, 1, E_MAIN, "R2");
        step(0, 0, 0, 1, 1, E_BATT, "R2");
        step(0, 0, 0, 1, 1, E_BATT, "R11");
        step(0, 1, 0, 1, 1, E_MAIN, "R3");
        step(0, 0, 0, 1, 1, E_BATT, "R9");
        step(1, 0, 0, 1, 1, E_MAIN_LO, "R3");
        step(1, 1, 0, 1, 1, E_MAIN, "R3");

        // Arm with both samples low, then drop the supply
        run_window(1, 0, 0, 1, 1);
        step(1, 1, 0, 1, 1, E_MAIN, "R5");
        step(0, 0, 0, 1, 1, E_SEAL_LO, "R5");
        step(0, 1, 0, 1, 1, E_SEAL_MAIN, "R7");
        step(0, 0, 0, 1, 1, E_SEAL_LO, "R7");
        step(1, 1, 0, 1, 1, E_MAIN, "R8");
        step(0, 0, 0, 1, 1, E_BATT, "R8");
        step(1, 1, 0, 1, 1, E_MAIN, "R8");

        // Only the half point low
        run_window(1, 0, 1, 1, 1);
        step(0, 0, 0, 1, 1, E_BATT, "R5");
        step(1, 1, 0, 1, 1, E_MAIN, "R5");

        // Only the three-quarter point low
        run_window(1, 1, 0, 1, 1);
        step(0, 0, 0, 1, 1, E_BATT, "R5");
        step(1, 1, 0, 1, 1, E_MAIN, "R5");

        // Low everywhere except the sample points
        run_window(0, 1, 1, 1, 1);
        step(0, 0, 0, 1, 1, E_BATT, "R5");
        step(1, 1, 0, 1, 1, E_MAIN, "R5");

        // Manual reset low at either sample point blocks arming
        run_window(1, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1, E_BATT, "R6");
        step(1, 1, 0, 1, 1, E_MAIN, "R6");
        run_window(1, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1, E_BATT, "R6");
        step(1, 1, 0, 1, 1, E_MAIN, "R6");

        // Manual reset low after arming has no effect
        run_window(1, 0, 0, 1, 1);
        step(1, 1, 0, 0, 1, E_MAIN, "R6");
        step(0, 0, 0, 0, 1, E_SEAL_LO, "R6");
        step(1, 1, 0, 1, 1, E_MAIN, "R8");

        // A second window discards the earlier arm
        run_window(1, 0, 0, 1, 1);
        run_window(1, 1, 1, 1, 1);
        step(0, 0, 0, 1, 1, E_BATT, "R10");
        step(1, 1, 0, 1, 1, E_MAIN, "R10");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule